// File: doc/BRIEF.md
# NAND Flash Strobe Timing Controller

This block sits between a simple 32-bit register bus and an 8-bit raw NAND flash device. Host writes to a command or address register become single latch cycles on the flash pins, and host writes or reads of a data register become single data cycles. Every cycle runs through setup, strobe, hold and ready-wait phases, whose lengths come from a timing register with separate read-side and write-side settings.

The host bus uses a request/acknowledge handshake. A register access is acknowledged in the cycle after it is accepted. A flash access is acknowledged only when its whole strobe cycle, including the ready-wait, has finished, so the host stalls for as long as the flash timing requires. The block also brings out the synchronised ready/busy line, a chip-enable override, a data-cycle countdown, sticky interrupt flags with a mask and a write-one-to-clear path, and a software reset.

Register word index is `addr_i[5:2]`. The map is: 0 command, 1 address, 2 data, 3 timing, 4 config, 5 control, 6 status, 7 data-cycle count, 8 interrupt flags, 9 interrupt mask, 10 interrupt clear.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: A write to the command register (index 0) runs one write cycle with `cle_o` high, `ale_o` low and `wdata_i[7:0]` on `io_o` for the whole cycle.
- R2: A write to the address register (index 1) runs one write cycle with `ale_o` high, `cle_o` low and `wdata_i[7:0]` on `io_o`.
- R3: A write to the data register (index 2) runs a write cycle with `cle_o` and `ale_o` low and `io_oe_o` high. A read of it runs a read cycle with `io_oe_o` low and `nre_o` pulsed, and returns the `io_i` byte sampled in the last strobe-low clock in `rdata_o[7:0]`, with the upper bits zero.
- R4: The timing register (index 3) holds, from bit 31 down, eight 4-bit counts: write ready-wait, write width, write hold, write setup, read ready-wait, read width, read hold, read setup. A cycle keeps the bus driven for setup+1 clocks before the strobe, holds the strobe low for width+1 clocks, keeps the bus for hold+1 clocks after it and then waits ready-wait clocks. The acknowledge comes setup+width+hold+ready-wait+4 clocks after the request is presented.
- R5: `ack_o` is a one-clock pulse. A register access is acknowledged one clock after the request is presented.
- R6: With the override clear, `nce_o` is low exactly during the setup, strobe and hold phases of a flash cycle, and high in ready-wait and idle.
- R7: Config bit 5 set holds `nce_o` low continuously, across and between cycles. Clearing it restores per-cycle control. The bit reads back at bit 5.
- R8: Status bit 0 (index 6) shows `rb_i` after a two-flop synchroniser, with 1 meaning ready.
- R9: Interrupt flag bit 0 sets on a rising edge of the synchronised ready line, and flag bit 1 sets when the data-cycle count reaches zero. Flags stay set until a write of one to the same bit of the clear register (index 10). `irq_o` is the OR of the flags ANDed with the mask register (index 9).
- R10: The data-cycle count (index 7) decrements by one at the end of each data read or data write cycle while it is non-zero. Command and address cycles leave it unchanged.
- R11: Writing control (index 5) with bit 2 set returns timing, config, count, mask and flags to their reset values.
- R12: After reset, `nce_o`, `nwe_o` and `nre_o` are high, `cle_o`, `ale_o`, `io_oe_o`, `ack_o` and `irq_o` are low, and the timing register reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until acknowledged |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | ADDR_W | Host byte address |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, valid with ack |
| ack_o | output | 1 | Access complete pulse |
| nce_o | output | 1 | Flash chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| nwe_o | output | 1 | Write strobe, active low |
| nre_o | output | 1 | Read strobe, active low |
| io_o | output | 8 | Flash I/O byte out |
| io_oe_o | output | 1 | Drive enable for io_o |
| io_i | input | 8 | Flash I/O byte in |
| rb_i | input | 1 | Flash ready/busy, 1 = ready |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions assume that the host keeps `req_i` high until it sees `ack_o` and drops it before the next clock edge. They also assume a single access is in flight at a time, so that the strobe lines and the latch enables only ever come from one cycle. The stimulus drives every request at the falling edge and releases it at the falling edge where the acknowledge is seen. It changes `rb_i` only at falling edges and with several idle clocks between changes, and it holds `io_i` constant for the whole of a read cycle, so the sampled byte is unambiguous.

// File: rtl/nand_ctrl_pkg.sv
`timescale 1ns/1ps
package nand_ctrl_pkg;
  typedef enum logic [3:0] {
    REG_CMD      = 4'd0,
    REG_ADDR     = 4'd1,
    REG_DATA     = 4'd2,
    REG_TIMING   = 4'd3,
    REG_CFG      = 4'd4,
    REG_CTRL     = 4'd5,
    REG_STATUS   = 4'd6,
    REG_XCNT     = 4'd7,
    REG_IRQ_FLAG = 4'd8,
    REG_IRQ_EN   = 4'd9,
    REG_IRQ_CLR  = 4'd10
  } reg_idx_e;

  // field order from msb is decoded by the sequencer
  typedef struct packed {
    logic [3:0] rdy;
    logic [3:0] width;
    logic [3:0] hold;
    logic [3:0] setup;
  } strobe_tim_t;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_WAIT} phase_e;
  typedef enum logic [1:0] {CYC_DATA, CYC_CMD, CYC_ADDR} cyc_kind_e;

  localparam int CFG_FORCE_CE = 5;
  localparam int CTRL_SRST    = 2;
  localparam int IRQ_RDY      = 0;
  localparam int IRQ_XFER     = 1;
  localparam int IRQ_N        = 2;
endpackage

// File: rtl/nand_rb_sync.sv
`timescale 1ns/1ps
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic rb_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // reset to ready so no false edge follows reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], rb_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rb_o   = sync_q[STAGES-1];
  assign rise_o = rb_o & ~last_q;
endmodule

// File: rtl/nand_phase_seq.sv
`timescale 1ns/1ps
module nand_phase_seq
  import nand_ctrl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  cyc_kind_e         kind_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  strobe_tim_t       tim_i,
  input  logic [BYTE_W-1:0] io_i,
  output logic              active_o,
  output logic              done_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [BYTE_W-1:0] io_o,
  output logic              io_oe_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  phase_e            phase_q;
  logic [3:0]        cnt_q;
  logic              rd_q;
  cyc_kind_e         kind_q;
  logic [BYTE_W-1:0] byte_q, rd_byte_q;
  strobe_tim_t       tim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      kind_q    <= CYC_DATA;
      byte_q    <= '0;
      rd_byte_q <= '0;
      tim_q     <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          cnt_q   <= tim_i.setup;
          rd_q    <= rd_i;
          kind_q  <= kind_i;
          byte_q  <= byte_i;
          tim_q   <= tim_i;
        end
        PH_SETUP: if (cnt_q == 0) begin
          phase_q <= PH_STROBE;
          cnt_q   <= tim_q.width;
        end else cnt_q <= cnt_q - 4'd1;
        PH_STROBE: if (cnt_q == 0) begin
          phase_q <= PH_HOLD;
          cnt_q   <= tim_q.hold;
          if (rd_q) rd_byte_q <= io_i;
        end else cnt_q <= cnt_q - 4'd1;
        PH_HOLD: if (cnt_q == 0) begin
          if (tim_q.rdy == 0) phase_q <= PH_IDLE;
          else begin
            phase_q <= PH_WAIT;
            cnt_q   <= tim_q.rdy;
          end
        end else cnt_q <= cnt_q - 4'd1;
        PH_WAIT: if (cnt_q <= 4'd1) phase_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 4'd1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign active_o  = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
  assign done_o    = ((phase_q == PH_HOLD) && (cnt_q == 0) && (tim_q.rdy == 0)) ||
                     ((phase_q == PH_WAIT) && (cnt_q <= 4'd1));
  assign cle_o     = active_o && (kind_q == CYC_CMD);
  assign ale_o     = active_o && (kind_q == CYC_ADDR);
  assign we_no     = !((phase_q == PH_STROBE) && !rd_q);
  assign re_no     = !((phase_q == PH_STROBE) && rd_q);
  assign io_oe_o   = active_o && !rd_q;
  assign io_o      = byte_q;
  assign rd_byte_o = rd_byte_q;
endmodule

// File: rtl/nand_irq_flags.sv
`timescale 1ns/1ps
module nand_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_d_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  for (genvar b = 0; b < N; b++) begin : g_flag
    // a new event wins over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_o[b] <= 1'b0;
      else if (srst_i)    flags_o[b] <= 1'b0;
      else if (set_i[b])  flags_o[b] <= 1'b1;
      else if (clr_i[b])  flags_o[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (srst_i)  en_o <= '0;
    else if (en_we_i) en_o <= en_d_i;
  end

  assign irq_o = |(flags_o & en_o);
endmodule

// File: rtl/nand_strobe_ctrl.sv
`timescale 1ns/1ps
module nand_strobe_ctrl
  import nand_ctrl_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          CNT_W   = 8,
  parameter int          SYNC_N  = 2,
  parameter logic [31:0] TIM_RST = 32'hFFFF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ack_o,
  output logic              nce_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              nwe_o,
  output logic              nre_o,
  output logic [7:0]        io_o,
  output logic              io_oe_o,
  input  logic [7:0]        io_i,
  input  logic              rb_i,
  output logic              irq_o
);
  localparam int BYTE_W = 8;

  logic [3:0]  idx;
  logic        accept, flash_op, start, reg_acc, reg_wr, srst;
  logic        ack_q, pend_q, pend_data_q;
  logic [31:0] rdata_q, rd_mux, timing_q;
  logic        force_q;
  logic [CNT_W-1:0] xcnt_q;
  logic        xfer_set;
  cyc_kind_e   kind;
  strobe_tim_t tim_sel;
  logic        seq_active, seq_done;
  logic [BYTE_W-1:0] rd_byte;
  logic        rb_sync, rb_rise;
  logic [IRQ_N-1:0] flags, irq_en;

  assign idx      = 4'(addr_i[ADDR_W-1:2]);
  assign flash_op = (idx == REG_DATA) || (we_i && ((idx == REG_CMD) || (idx == REG_ADDR)));
  assign accept   = req_i && !ack_q && !pend_q;
  assign start    = accept && flash_op;
  assign reg_acc  = accept && !flash_op;
  assign reg_wr   = reg_acc && we_i;
  assign srst     = reg_wr && (idx == REG_CTRL) && wdata_i[CTRL_SRST];

  always_comb begin
    unique case (idx)
      REG_CMD:  kind = CYC_CMD;
      REG_ADDR: kind = CYC_ADDR;
      default:  kind = CYC_DATA;
    endcase
  end
  assign tim_sel = we_i ? strobe_tim_t'(timing_q[31:16]) : strobe_tim_t'(timing_q[15:0]);

  nand_phase_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i  (start),
    .rd_i     (!we_i),
    .kind_i   (kind),
    .byte_i   (wdata_i[BYTE_W-1:0]),
    .tim_i    (tim_sel),
    .io_i,
    .active_o (seq_active),
    .done_o   (seq_done),
    .cle_o, .ale_o,
    .we_no    (nwe_o),
    .re_no    (nre_o),
    .io_o, .io_oe_o,
    .rd_byte_o(rd_byte)
  );

  nand_rb_sync #(.STAGES(SYNC_N)) u_rb (
    .clk_i, .rst_ni, .rb_i,
    .rb_o  (rb_sync),
    .rise_o(rb_rise)
  );

  logic [IRQ_N-1:0] irq_set, irq_clr;
  assign irq_set = {xfer_set, rb_rise};
  assign irq_clr = (reg_wr && (idx == REG_IRQ_CLR)) ? wdata_i[IRQ_N-1:0] : '0;

  nand_irq_flags #(.N(IRQ_N)) u_irq (
    .clk_i, .rst_ni,
    .srst_i (srst),
    .set_i  (irq_set),
    .clr_i  (irq_clr),
    .en_we_i(reg_wr && (idx == REG_IRQ_EN)),
    .en_d_i (wdata_i[IRQ_N-1:0]),
    .flags_o(flags),
    .en_o   (irq_en),
    .irq_o
  );

  assign xfer_set = seq_done && pend_data_q && (xcnt_q == CNT_W'(1));

  always_comb begin
    rd_mux = '0;
    unique case (idx)
      REG_TIMING:   rd_mux = timing_q;
      REG_CFG:      rd_mux[CFG_FORCE_CE] = force_q;
      REG_STATUS:   rd_mux[0] = rb_sync;
      REG_XCNT:     rd_mux[CNT_W-1:0] = xcnt_q;
      REG_IRQ_FLAG: rd_mux[IRQ_N-1:0] = flags;
      REG_IRQ_EN:   rd_mux[IRQ_N-1:0] = irq_en;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_data_q <= 1'b0;
      rdata_q     <= '0;
      timing_q    <= TIM_RST;
      force_q     <= 1'b0;
      xcnt_q      <= '0;
    end else begin
      ack_q <= reg_acc || seq_done;
      if (start) begin
        pend_q      <= 1'b1;
        pend_data_q <= (idx == REG_DATA);
      end else if (seq_done) pend_q <= 1'b0;
      if (reg_acc)       rdata_q <= rd_mux;
      else if (seq_done) rdata_q <= {{(32-BYTE_W){1'b0}}, rd_byte};
      if (srst) begin
        timing_q <= TIM_RST;
        force_q  <= 1'b0;
        xcnt_q   <= '0;
      end else begin
        if (reg_wr && (idx == REG_TIMING)) timing_q <= wdata_i;
        if (reg_wr && (idx == REG_CFG))    force_q  <= wdata_i[CFG_FORCE_CE];
        if (reg_wr && (idx == REG_XCNT))   xcnt_q   <= wdata_i[CNT_W-1:0];
        else if (seq_done && pend_data_q && (xcnt_q != '0)) xcnt_q <= xcnt_q - CNT_W'(1);
      end
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
  assign nce_o   = !(force_q || seq_active);
endmodule

// File: rtl/nand_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module nand_strobe_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_o,
  input logic       nce_o,
  input logic       cle_o,
  input logic       ale_o,
  input logic       nwe_o,
  input logic       nre_o,
  input logic [7:0] io_o,
  input logic       io_oe_o,
  input logic       ce_force_i
);
  a_r1_latch_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nwe_o && !nre_o));
  a_r3_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nre_o |-> !io_oe_o);
  a_r4_io_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nwe_o && $past(!nwe_o)) |-> $stable(io_o));
  a_r5_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r6_strobe_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nwe_o || !nre_o) |-> !nce_o);
  a_r7_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_force_i |-> !nce_o);
endmodule

bind nand_strobe_ctrl nand_strobe_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .nce_o(nce_o),
  .cle_o(cle_o), .ale_o(ale_o), .nwe_o(nwe_o), .nre_o(nre_o),
  .io_o(io_o), .io_oe_o(io_oe_o), .ce_force_i(force_q)
);

// File: tb/nand_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module nand_strobe_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req = 0, we = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic ack, nce, cle, ale, nwe, nre, io_oe, irq;
  logic [7:0] io_out, io_in = '0;
  logic rb = 1'b1;

  nand_strobe_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .nce_o(nce), .cle_o(cle),
    .ale_o(ale), .nwe_o(nwe), .nre_o(nre), .io_o(io_out), .io_oe_o(io_oe),
    .io_i(io_in), .rb_i(rb), .irq_o(irq)
  );

  int total = 0, bad = 0;
  int n_tot, n_strb, n_pre, n_post, n_bus;
  bit seen_cle, seen_ale, seen_oe;
  logic [7:0] strobe_io;
  logic [31:0] rd_val;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic host(input logic w, input logic [3:0] idx, input logic [31:0] d);
    bit strobe_seen = 0;
    n_tot = 0; n_strb = 0; n_pre = 0; n_post = 0; n_bus = 0;
    seen_cle = 0; seen_ale = 0; seen_oe = 0; strobe_io = '0;
    @(negedge clk);
    req = 1; we = w; addr = {idx, 2'b00}; wdata = d;
    forever begin
      @(negedge clk);
      n_tot++;
      if (!nce) n_bus++;
      if (!nwe || !nre) begin
        n_strb++; strobe_seen = 1; strobe_io = io_out;
      end else if (!nce) begin
        if (strobe_seen) n_post++; else n_pre++;
      end
      if (cle) seen_cle = 1;
      if (ale) seen_ale = 1;
      if (io_oe) seen_oe = 1;
      if (ack) begin rd_val = rdata; req = 0; break; end
      if (n_tot > 3000) begin chk("R5 no ack", 0, 1); req = 0; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 nce", nce, 1); chk("R12 nwe", nwe, 1); chk("R12 nre", nre, 1);
    chk("R12 cle", cle, 0); chk("R12 ale", ale, 0); chk("R12 oe", io_oe, 0);
    chk("R12 ack", ack, 0); chk("R12 irq", irq, 0);
    rst_n = 1;
    host(0, 4'd3, 0);
    chk("R12 timing default", rd_val, 32'hFFFF_FFFF);
    chk("R5 reg ack latency", n_tot, 1);
    @(negedge clk);
    chk("R5 ack one clock", ack, 0);

    // R4/R1/R3 sweep over phase lengths
    foreach (v[a]) foreach (v[b]) foreach (v[c]) foreach (v[e]) begin
      int s = v[a], w = v[b], h = v[c], r = v[e];
      logic [31:0] tv;
      logic [7:0] cb;
      tv = {4'(r), 4'(w), 4'(h), 4'(s), 4'(h), 4'(s), 4'(r), 4'(w)};
      host(1, 4'd3, tv);
      cb = 8'(8'hA0 ^ (a*27 + b*9 + c*3 + e));
      host(1, 4'd0, {24'hFFFFFF, cb});
      chk("R4 write setup", n_pre, s + 1);
      chk("R4 write width", n_strb, w + 1);
      chk("R4 write hold", n_post, h + 1);
      chk("R4 write total", n_tot, s + w + h + r + 4);
      chk("R6 nce window write", n_bus, s + w + h + 3);
      chk("R1 cle", {seen_ale, seen_cle}, 2'b01);
      chk("R1 byte", strobe_io, cb);
      io_in = ~cb;
      host(0, 4'd2, 0);
      chk("R4 read setup", n_pre, w + 1);
      chk("R4 read width", n_strb, s + 1);
      chk("R4 read hold", n_post, r + 1);
      chk("R4 read total", n_tot, w + s + r + h + 4);
      chk("R3 read released", {seen_oe, seen_cle, seen_ale}, 3'b000);
      chk("R3 read data", rd_val, {24'h0, ~cb});
    end

    host(1, 4'd3, 32'h1021_1021);
    host(1, 4'd1, 32'h0000_005A);
    chk("R2 ale", {seen_ale, seen_cle}, 2'b10);
    chk("R2 byte", strobe_io, 8'h5A);
    host(1, 4'd2, 32'h0000_00C3);
    chk("R3 write data", {seen_oe, seen_cle, seen_ale}, 3'b100);
    chk("R3 write byte", strobe_io, 8'hC3);

    // R7 chip-enable override
    host(1, 4'd4, 32'h20);
    @(negedge clk); chk("R7 forced idle", nce, 0);
    host(1, 4'd0, 32'h11);
    @(negedge clk); chk("R7 forced after cycle", nce, 0);
    host(0, 4'd4, 0); chk("R7 readback", rd_val, 32'h20);
    host(1, 4'd4, 0);
    @(negedge clk); chk("R7 released", nce, 1);

    // R8/R9 ready line
    host(1, 4'd10, 3);
    host(1, 4'd9, 1);
    @(negedge clk); rb = 0;
    repeat (5) @(negedge clk);
    host(0, 4'd6, 0); chk("R8 busy", rd_val, 0);
    host(0, 4'd8, 0); chk("R9 no flag on fall", rd_val, 0);
    rb = 1;
    repeat (5) @(negedge clk);
    host(0, 4'd6, 0); chk("R8 ready", rd_val, 1);
    host(0, 4'd8, 0); chk("R9 rdy flag", rd_val, 1);
    chk("R9 irq", irq, 1);
    host(1, 4'd10, 1);
    host(0, 4'd8, 0); chk("R9 cleared", rd_val, 0);
    chk("R9 irq low", irq, 0);

    // R10/R9 data-cycle count
    host(1, 4'd9, 2);
    host(1, 4'd7, 2);
    host(1, 4'd2, 1);
    host(0, 4'd7, 0); chk("R10 dec", rd_val, 1);
    host(0, 4'd8, 0); chk("R9 xfer not yet", rd_val, 0);
    host(1, 4'd0, 8'h70);
    host(1, 4'd1, 8'h01);
    host(0, 4'd7, 0); chk("R10 cmd/addr ignored", rd_val, 1);
    host(0, 4'd2, 0);
    host(0, 4'd7, 0); chk("R10 zero", rd_val, 0);
    host(0, 4'd8, 0); chk("R9 xfer flag", rd_val, 2);
    chk("R9 xfer irq", irq, 1);
    host(1, 4'd2, 1);
    host(0, 4'd7, 0); chk("R10 holds at zero", rd_val, 0);

    // R11 software reset
    host(1, 4'd3, 32'h1234_5678);
    host(1, 4'd4, 32'h20);
    host(1, 4'd5, 32'h4);
    host(0, 4'd3, 0); chk("R11 timing", rd_val, 32'hFFFF_FFFF);
    host(0, 4'd4, 0); chk("R11 cfg", rd_val, 0);
    host(0, 4'd9, 0); chk("R11 mask", rd_val, 0);
    host(0, 4'd8, 0); chk("R11 flags", rd_val, 0);
    chk("R11 nce", nce, 1);
    chk("R11 irq", irq, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule